// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of one SIMD thread are enabled while control flow splits and rejoins. Every lane executes every instruction, and the active mask from this block decides which lanes commit a result. When the issue stage reaches a divergent branch, it asserts `push_i` together with the per-lane predicate from the preceding compare. The block saves the current mask and narrows the active set to the lanes whose predicate is true. At the start of the else path, the issue stage asserts `comp_i` with the same predicate. The block then enables the lanes that were active before the branch and whose predicate is false. At the reconvergence point, `pop_i` restores the saved mask.

Branches can nest up to `DEPTH` levels, and saved masks are restored in last-in, first-out order. When the current path has no enabled lane, `skip_o` rises so that the issue stage can jump past that path. A push into a full stack raises `overflow_o`. A pop or complement on an empty stack raises `underflow_o`. In either case the rejected command leaves the mask and the stack untouched.

Occupancy is held by a three-state machine:
- EMPTY: no saved mask. A push moves it to PARTIAL, or to FULL when `DEPTH` is 1.
- PARTIAL: some entries are in use. A push that fills the last entry moves it to FULL. A pop of the last entry moves it to EMPTY.
- FULL: all `DEPTH` entries are in use. A pop moves it to PARTIAL, or to EMPTY when `DEPTH` is 1.

A complement never changes the state.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, no error flag is high, and the stack is empty, so a first pop reports underflow.
- R2: An accepted push saves the current mask as the new top entry, and one cycle later the mask equals the old mask ANDed with `pred_i`.
- R3: An accepted complement sets the mask to the top saved entry ANDed with the inverse of `pred_i`. The stack contents and depth are unchanged.
- R4: An accepted pop restores the top saved entry and removes it. Across nesting up to `DEPTH` levels, entries come back in last-in, first-out order.
- R5: `any_active_o` is high exactly when at least one mask bit is set. `skip_o` is high exactly when the mask is all zeros.
- R6: A push while `DEPTH` entries are held is rejected. `overflow_o` is high for exactly the one cycle after the clock edge that sampled it, and the mask and stack stay unchanged.
- R7: A pop or complement while the stack is empty is rejected. `underflow_o` is high for exactly the one cycle after the clock edge that sampled it, and the mask stays unchanged.
- R8: When several commands are asserted in one cycle, only one acts: push before complement, and complement before pop.
- R9: In a cycle with no command, the mask and the stack hold their values, and both error flags are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Divergent branch: save mask and narrow it by the predicate |
| comp_i | input | 1 | Else point: enable saved lanes whose predicate is false |
| pop_i | input | 1 | Reconvergence: restore the saved mask |
| pred_i | input | LANES | Per-lane predicate bits, used by push and complement |
| active_mask_o | output | LANES | Current per-lane commit enable |
| any_active_o | output | 1 | At least one lane is enabled on the current path |
| skip_o | output | 1 | No lane is enabled; the issue stage may skip the path |
| overflow_o | output | 1 | One-cycle pulse: push rejected because the stack is full |
| underflow_o | output | 1 | One-cycle pulse: pop or complement rejected because the stack is empty |

## Verification
A wrong mask computation shows on `active_mask_o` in the cycle after the command. A corrupted saved entry stays hidden until the complement or pop at that nesting level, which can be many commands later. For this reason the bench runs long random sequences that nest down to full depth and then unwind. An occupancy count that is off by one appears as an error pulse in the wrong cycle, or as a missing pulse, at the first push into a full stack or the first pop from an empty one.

// File: rtl/simt_mask_pkg.sv
`timescale 1ns/1ps
package simt_mask_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_COMP,
        OP_POP
    } mask_op_e;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;

    // Push wins over complement, complement wins over pop.
    function automatic mask_op_e pick_op(input logic push, input logic comp,
                                         input logic pop);
        if (push)      return OP_PUSH;
        else if (comp) return OP_COMP;
        else if (pop)  return OP_POP;
        else           return OP_IDLE;
    endfunction

endpackage

// File: rtl/smk_ctrl.sv
`timescale 1ns/1ps
module smk_ctrl
    import simt_mask_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic           comp_i,
    input  logic           pop_i,
    output mask_op_e       op_o,
    output logic [IW-1:0]  wr_idx_o,
    output logic [IW-1:0]  rd_idx_o,
    output logic           ovf_o,
    output logic           udf_o
);

    occ_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            ovf_q, ovf_d, udf_q, udf_d;
    mask_op_e        req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovf_q   <= ovf_d;
            udf_q   <= udf_d;
        end
    end

    // Next state and accepted operation
    always_comb begin
        req     = pick_op(push_i, comp_i, pop_i);
        op_o    = OP_IDLE;
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf_d   = 1'b0;
        udf_d   = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                if (req == OP_PUSH) begin
                    op_o    = OP_PUSH;
                    cnt_d   = cnt_q + CW'(1);
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end else if (req != OP_IDLE) begin
                    udf_d = 1'b1;
                end
            end
            OCC_PARTIAL: begin
                op_o = req;
                if (req == OP_PUSH) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == CW'(DEPTH - 1)) state_d = OCC_FULL;
                end else if (req == OP_POP) begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (req == OP_PUSH) begin
                    ovf_d = 1'b1;
                end else begin
                    op_o = req;
                    if (req == OP_POP) begin
                        cnt_d   = cnt_q - CW'(1);
                        state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                    end
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        wr_idx_o = IW'(cnt_q);
        rd_idx_o = IW'(cnt_q - CW'(1));
        ovf_o    = ovf_q;
        udf_o    = udf_q;
    end

endmodule

// File: rtl/smk_store.sv
`timescale 1ns/1ps
module smk_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [LANES-1:0] wr_data_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [LANES-1:0] rd_data_o
);

    logic [LANES-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == IW'(g)))
                ent_q[g] <= wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == IW'(i)) rd_data_o = ent_q[i];
        end
    end

endmodule

// File: rtl/smk_mask.sv
`timescale 1ns/1ps
module smk_mask
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mask_op_e         op_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] top_i,
    output logic [LANES-1:0] mask_o
);

    logic [LANES-1:0] mask_q, mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    always_comb begin
        unique case (op_i)
            OP_PUSH: mask_d = mask_q & pred_i;
            OP_COMP: mask_d = top_i & ~pred_i;
            OP_POP:  mask_d = top_i;
            default: mask_d = mask_q;
        endcase
        mask_o = mask_q;
    end

endmodule

// File: rtl/simt_mask_stack.sv
`timescale 1ns/1ps
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             comp_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] active_mask_o,
    output logic             any_active_o,
    output logic             skip_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mask_op_e         op;
    logic [IW-1:0]    wr_idx, rd_idx;
    logic [LANES-1:0] top, mask;

    smk_ctrl #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .comp_i   (comp_i),
        .pop_i    (pop_i),
        .op_o     (op),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .ovf_o    (overflow_o),
        .udf_o    (underflow_o)
    );

    smk_store #(.LANES(LANES), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (op == OP_PUSH),
        .wr_idx_i  (wr_idx),
        .wr_data_i (mask),
        .rd_idx_i  (rd_idx),
        .rd_data_o (top)
    );

    smk_mask #(.LANES(LANES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .pred_i (pred_i),
        .top_i  (top),
        .mask_o (mask)
    );

    assign active_mask_o = mask;
    assign any_active_o  = |mask;
    assign skip_o        = ~|mask;

endmodule

// File: rtl/smk_checker.sv
`timescale 1ns/1ps
module smk_checker #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             comp_i,
    input logic             pop_i,
    input logic [LANES-1:0] pred_i,
    input logic [LANES-1:0] active_mask_o,
    input logic             overflow_o,
    input logic             underflow_o
);

    localparam int CW = $clog2(DEPTH + 1);

    // Occupancy as seen from the command ports
    logic [CW-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else if (push_i) begin
            if (lvl_q != CW'(DEPTH)) lvl_q <= lvl_q + CW'(1);
        end else if (!comp_i && pop_i && lvl_q != '0)
            lvl_q <= lvl_q - CW'(1);
    end

    AST_EMPTY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |-> (&active_mask_o));                                       // R1
    AST_PUSH_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && lvl_q != CW'(DEPTH)) |=>
            active_mask_o == ($past(active_mask_o) & $past(pred_i)));              // R2
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && lvl_q == CW'(DEPTH)) |=> overflow_o);                           // R6
    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> active_mask_o == $past(active_mask_o));                     // R6
    AST_UDF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> active_mask_o == $past(active_mask_o));                    // R7
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_o && underflow_o));                                             // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !comp_i && !pop_i) |=>
            ($stable(active_mask_o) && !overflow_o && !underflow_o));              // R9

endmodule

bind simt_mask_stack smk_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .comp_i        (comp_i),
    .pop_i         (pop_i),
    .pred_i        (pred_i),
    .active_mask_o (active_mask_o),
    .overflow_o    (overflow_o),
    .underflow_o   (underflow_o)
);

// File: tb/tb_simt_mask_stack.sv
`timescale 1ns/1ps
module tb_simt_mask_stack;

    localparam int LANES = 32;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
    logic [LANES-1:0] pred_i = '0;
    logic [LANES-1:0] active_mask_o;
    logic             any_active_o, skip_o, overflow_o, underflow_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state
    logic [LANES-1:0] m_mask;
    logic [LANES-1:0] m_stk [DEPTH];
    int               m_lvl;
    bit               e_ovf, e_udf;

    always #2.5 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .comp_i(comp_i), .pop_i(pop_i),
        .pred_i(pred_i), .active_mask_o(active_mask_o), .any_active_o(any_active_o),
        .skip_o(skip_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk_vec(string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s mask act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    function automatic string pick_tag(bit p, bit c, bit q);
        if (int'(p) + int'(c) + int'(q) > 1) return "R8";
        if (p) return (m_lvl == DEPTH) ? "R6" : "R2";
        if (c) return (m_lvl == 0) ? "R7" : "R3";
        if (q) return (m_lvl == 0) ? "R7" : "R4";
        return "R9";
    endfunction

    // Expected next state, with push before complement before pop
    task automatic model_step(bit p, bit c, bit q, logic [LANES-1:0] pr);
        e_ovf = 1'b0;
        e_udf = 1'b0;
        if (p) begin
            if (m_lvl == DEPTH) e_ovf = 1'b1;
            else begin
                m_stk[m_lvl] = m_mask;
                m_lvl++;
                m_mask = m_mask & pr;
            end
        end else if (c) begin
            if (m_lvl == 0) e_udf = 1'b1;
            else m_mask = m_stk[m_lvl-1] & ~pr;
        end else if (q) begin
            if (m_lvl == 0) e_udf = 1'b1;
            else begin
                m_lvl--;
                m_mask = m_stk[m_lvl];
            end
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(bit p, bit c, bit q, logic [LANES-1:0] pr);
        string tag;
        tag    = pick_tag(p, c, q);
        push_i = p; comp_i = c; pop_i = q; pred_i = pr;
        @(negedge clk);
        model_step(p, c, q, pr);
        chk_vec(tag, active_mask_o, m_mask);
        chk_bit(tag, "overflow", overflow_o, e_ovf);
        chk_bit(tag, "underflow", underflow_o, e_udf);
        chk_bit("R5", "any_active", any_active_o, |m_mask);
        chk_bit("R5", "skip", skip_o, ~|m_mask);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mask = '1;
        m_lvl  = 0;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_vec("R1", active_mask_o, '1);
        chk_bit("R1", "overflow", overflow_o, 1'b0);
        chk_bit("R1", "underflow", underflow_o, 1'b0);
        step(0, 0, 1, '0);                    // R1 R7: pop on empty stack
        step(0, 1, 0, 32'h0000_FFFF);         // R7: complement on empty stack
        step(0, 0, 0, '0);                    // R9: idle

        // R2 R6: nest to full depth, then overflow
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, ~(32'h1 << (i * 3)));
        step(1, 0, 0, '0);                    // R6
        step(0, 0, 0, '0);                    // R9
        step(0, 1, 0, 32'hF0F0_F0F0);         // R3 at full depth
        // R4: unwind in LIFO order, then underflow
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, '0);
        step(0, 0, 1, '0);                    // R7

        // R5: empty path and inverse path
        step(1, 0, 0, '0);
        step(0, 1, 0, '0);
        step(0, 0, 1, '0);
        // R8: simultaneous commands
        step(1, 0, 1, 32'h00FF_00FF);
        step(0, 1, 1, 32'h0F0F_0F0F);
        step(1, 1, 1, 32'h3333_3333);
        step(0, 0, 1, '0);
        step(0, 0, 1, '0);

        // Random sequences
        for (int n = 0; n < 3000; n++) begin
            int r;
            bit p, c, q;
            logic [LANES-1:0] pr;
            r = int'($urandom_range(0, 99));
            p = (r < 40);
            c = (r >= 40 && r < 60);
            q = (r >= 60 && r < 88);
            if (r >= 95) begin
                p = 1'(($urandom & 1) != 0);
                c = 1'(($urandom & 1) != 0);
                q = 1'b1;
            end
            case ($urandom_range(0, 5))
                0:       pr = '0;
                1:       pr = '1;
                default: pr = $urandom;
            endcase
            step(p, c, q, pr);
        end

        push_i = 0; comp_i = 0; pop_i = 0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule